// File: doc/BRIEF.md
# Banked register access controller

This block sits behind a serial slave protocol engine and turns each single-byte register access, given as a 7-bit address, a read or write strobe and a data byte, into an access to the right backing store. The lower half of the address space (0x00 to 0x3F) is a 64-byte window into one of sixteen banks. The byte held at direct address 0x40 selects the bank. The upper half (0x40 to 0x7F) is a fixed set of direct registers held inside the block. These include the bank select byte and identification bytes that come out of reset with fixed values.

Each access is checked against a protection policy. The policy is chosen by a single protection bit, which the system takes from bit 3 of configuration byte 0x03 and presents on `cfg_prot`. The bank classes are treated differently:

- Bank 0 holds configuration data.
- Banks 1 to 7 hold data-sheet content.
- Banks 8 to 15 hold user data.

A denied access has no effect on any store. It is reported by a one-cycle error pulse, and a denied read returns zero. Window writes go straight to the external bank store as a bank number, an offset and a write enable. Window reads take the store's combinational read data. All read results are registered.

Top module: `bank_access_ctrl`

## Requirements
- R1: After reset `rdata` is 0x00, `rd_valid` and `access_error` are 0, and the bank select byte (0x40) reads 0x00. Direct registers 0x78..0x7F read 4E, 51, 43, 31, 00, 00, 69, 43 in address order, and all other direct registers read 0x00.
- R2: For an address below 0x40, `win_bank` equals the low 4 bits of the bank select byte and `win_offset` equals address bits 5:0, combinationally. An allowed window write raises `win_we` in the same cycle as `wr_en`.
- R3: A read strobe (`rd_en`=1, `wr_en`=0) is answered on the next clock edge: `rd_valid` is 1 for exactly one cycle and `rdata` holds the result until the next read. If both strobes are high, the write is performed and the read is ignored.
- R4: With `cfg_prot`=0, every read and write in every region is accepted and `access_error` stays 0.
- R5: With `cfg_prot`=1, reads and writes to the window while bank 0 is selected are denied.
- R6: With `cfg_prot`=1, the window for banks 1 to 7 is read-only: reads succeed and writes are denied.
- R7: With `cfg_prot`=1, the window for banks 8 to 15 allows both reads and writes.
- R8: With `cfg_prot`=1, direct registers 0x40..0x7F are read-only, except that writes to 0x40 and 0x7C are always accepted.
- R9: A denied write changes no store and raises `access_error` for one cycle after the strobe. A denied read returns `rdata`=0x00 with `access_error`=1 in the same cycle as `rd_valid`.
- R10: A bank select value above 15 is stored as written. While it holds, window reads return 0x00, window writes do not raise `win_we`, and neither raises `access_error`.
- R11: An accepted write to a direct address stores `wdata`, and a later read of that address returns it. The bank select byte at 0x40 reads back the full 8-bit value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | 7 | Register address |
| wdata | input | 8 | Write data; also fed to the bank store |
| cfg_prot | input | 1 | Protection level bit from configuration byte 0x03 |
| win_rdata | input | 8 | Combinational read data of the bank store at `win_bank`/`win_offset` |
| win_bank | output | 4 | Bank number presented to the bank store |
| win_offset | output | 6 | Byte offset within the bank |
| win_we | output | 1 | Write enable to the bank store |
| rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | One-cycle pulse marking `rdata` valid |
| access_error | output | 1 | One-cycle pulse for a denied access |

## Verification
The assertions assume that `cfg_prot` is stable for the whole cycle of a strobe. They also assume that the bank store answers `win_rdata` combinationally from the bank and offset the block drives. The one-cycle timing checks further assume that `rd_en` and `wr_en` are not raised together. The stimulus meets these assumptions: the protection bit, address and data change only on the falling clock edge together with a single strobe. The bank store model reads combinationally and writes only on the rising edge when `win_we` is high.

// File: rtl/bac_pkg.sv
package bac_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 7;
  localparam int BANK_W = 4;
  localparam int OFS_W  = ADDR_W - 1;
  localparam int NUM_DIRECT = 1 << OFS_W;

  typedef enum logic [2:0] {
    RG_CFG    = 3'd0,
    RG_EDS    = 3'd1,
    RG_USER   = 3'd2,
    RG_NOBANK = 3'd3,
    RG_DIRECT = 3'd4
  } region_t;

  // Region of an access: top address bit picks the direct half.
  function automatic region_t region_of(logic upper, logic [DATA_W-1:0] bank_sel);
    if (upper)                                   return RG_DIRECT;
    else if (bank_sel >= DATA_W'(1 << BANK_W))   return RG_NOBANK;
    else if (bank_sel == '0)                     return RG_CFG;
    else if (!bank_sel[BANK_W-1])                return RG_EDS;
    else                                         return RG_USER;
  endfunction

  // Protection policy; ofs is the offset within the direct half.
  function automatic logic access_ok(region_t rg, logic prot, logic is_wr,
                                     logic [OFS_W-1:0] ofs);
    if (!prot) return 1'b1;
    case (rg)
      RG_CFG:    return 1'b0;
      RG_EDS:    return !is_wr;
      RG_DIRECT: return !is_wr || (ofs == OFS_W'(0)) || (ofs == OFS_W'(6'h3C));
      default:   return 1'b1;
    endcase
  endfunction

  // Reset value of direct register at offset idx from 0x40.
  function automatic logic [DATA_W-1:0] direct_default(int unsigned idx);
    case (idx)
      32'h38:  return DATA_W'(8'h4E);
      32'h39:  return DATA_W'(8'h51);
      32'h3A:  return DATA_W'(8'h43);
      32'h3B:  return DATA_W'(8'h31);
      32'h3E:  return DATA_W'(8'h69);
      32'h3F:  return DATA_W'(8'h43);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/bac_decode.sv
module bac_decode
  import bac_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] bank_sel,
  output region_t           region,
  output logic [BANK_W-1:0] bank,
  output logic [OFS_W-1:0]  ofs
);
  always_comb begin
    region = region_of(addr[ADDR_W-1], bank_sel);
    bank   = bank_sel[BANK_W-1:0];
    ofs    = addr[OFS_W-1:0];
  end
endmodule

// File: rtl/bac_policy.sv
module bac_policy
  import bac_pkg::*;
(
  input  region_t          region,
  input  logic             prot,
  input  logic             is_wr,
  input  logic [OFS_W-1:0] ofs,
  output logic             allow
);
  always_comb allow = access_ok(region, prot, is_wr, ofs);
endmodule

// File: rtl/bac_direct_regs.sv
module bac_direct_regs
  import bac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [OFS_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] bank_sel
);
  logic [DATA_W-1:0] regs [NUM_DIRECT];

  for (genvar g = 0; g < NUM_DIRECT; g++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL = direct_default(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs[g] <= RST_VAL;
      else if (we && idx == OFS_W'(g))     regs[g] <= wdata;
    end
  end

  assign rd_data  = regs[idx];
  assign bank_sel = regs[0];
endmodule

// File: rtl/bank_access_ctrl.sv
module bank_access_ctrl
  import bac_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  localparam int BW = BANK_W,
  localparam int OW = AW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          cfg_prot,
  input  logic [DW-1:0] win_rdata,
  output logic [BW-1:0] win_bank,
  output logic [OW-1:0] win_offset,
  output logic          win_we,
  output logic [DW-1:0] rdata,
  output logic          rd_valid,
  output logic          access_error
);
  region_t       region;
  logic          is_rd, is_wr, allow, dir_we, in_window;
  logic [DW-1:0] bank_sel, dir_rdata, rd_next;

  assign is_wr = wr_en;
  assign is_rd = rd_en & ~wr_en;

  bac_decode u_decode (
    .addr(addr), .bank_sel(bank_sel),
    .region(region), .bank(win_bank), .ofs(win_offset)
  );

  bac_policy u_policy (
    .region(region), .prot(cfg_prot), .is_wr(is_wr),
    .ofs(win_offset), .allow(allow)
  );

  bac_direct_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(dir_we), .idx(win_offset),
    .wdata(wdata), .rd_data(dir_rdata), .bank_sel(bank_sel)
  );

  assign in_window = (region == RG_CFG) || (region == RG_EDS) || (region == RG_USER);
  assign win_we    = is_wr && allow && in_window;
  assign dir_we    = is_wr && allow && (region == RG_DIRECT);

  always_comb begin
    rd_next = '0;
    if (allow) begin
      if (region == RG_DIRECT) rd_next = dir_rdata;
      else if (in_window)      rd_next = win_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata        <= '0;
      rd_valid     <= 1'b0;
      access_error <= 1'b0;
    end else begin
      rd_valid     <= is_rd;
      access_error <= (is_rd || is_wr) && !allow;
      if (is_rd) rdata <= rd_next;
    end
  end

  // R3: a read strobe is answered on the next edge, and only then
  a_r3_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> rd_valid);
  a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R9: denied read yields zero data; an error always follows a strobe
  a_r9_denied_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && access_error) |-> (rdata == '0));
  a_r9_error_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    access_error |-> $past(rd_en || wr_en));
  // R4: unprotected accesses never raise an error
  a_r4_open_when_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_prot && (rd_en || wr_en)) |=> !access_error);
  // R5 R6 R7: under protection only user banks reach the store write port
  a_r6_prot_window_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_prot && win_we) |-> win_bank[BW-1]);
  // R8: protected direct writes only at the two exempt addresses
  a_r8_prot_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_prot && dir_we) |-> (addr == AW'(7'h40) || addr == AW'(7'h7C)));
  // R10: an out-of-range bank never produces an error
  a_r10_bad_bank_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && !addr[AW-1] && bank_sel > DW'(15)) |=> !access_error);
endmodule

// File: tb/bank_access_ctrl_test.sv
module bank_access_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0, cfg_prot = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] win_rdata;
  logic [3:0] win_bank;
  logic [5:0] win_offset;
  logic       win_we;
  logic [7:0] rdata;
  logic       rd_valid, access_error;

  int compared = 0, mismatched = 0, store_writes = 0;
  logic [7:0] mem [16][64];

  always #10 clk = ~clk;

  bank_access_ctrl uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .cfg_prot(cfg_prot), .win_rdata(win_rdata),
    .win_bank(win_bank), .win_offset(win_offset), .win_we(win_we),
    .rdata(rdata), .rd_valid(rd_valid), .access_error(access_error)
  );

  assign win_rdata = mem[win_bank][win_offset];
  always @(posedge clk) if (win_we) begin
    mem[win_bank][win_offset] <= wdata;
    store_writes <= store_writes + 1;
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Fields: op(2: 1=read 2=write) prot(1) addr(7) wdata(8) exp_data(8) exp_err(1) req(4)
  localparam int NV = 34;
  localparam logic [30:0] VEC [NV] = '{
    {2'd2,1'b0,7'h05,8'hAA,8'h00,1'b0,4'd4},  // R4
    {2'd1,1'b0,7'h05,8'h00,8'hAA,1'b0,4'd4},  // R4
    {2'd2,1'b0,7'h40,8'h03,8'h00,1'b0,4'd11}, // R11 bank 3
    {2'd2,1'b0,7'h10,8'h5C,8'h00,1'b0,4'd2},  // R2
    {2'd2,1'b0,7'h11,8'h33,8'h00,1'b0,4'd4},  // R4
    {2'd1,1'b0,7'h40,8'h00,8'h03,1'b0,4'd11}, // R11
    {2'd1,1'b0,7'h10,8'h00,8'h5C,1'b0,4'd2},  // R2
    {2'd2,1'b1,7'h11,8'h77,8'h00,1'b1,4'd6},  // R6 write denied
    {2'd1,1'b1,7'h11,8'h00,8'h33,1'b0,4'd6},  // R6 read ok, old data
    {2'd2,1'b1,7'h40,8'h09,8'h00,1'b0,4'd8},  // R8 exempt 0x40, bank 9
    {2'd2,1'b1,7'h20,8'hE1,8'h00,1'b0,4'd7},  // R7
    {2'd1,1'b1,7'h20,8'h00,8'hE1,1'b0,4'd7},  // R7
    {2'd2,1'b1,7'h40,8'h00,8'h00,1'b0,4'd8},  // R8 bank 0
    {2'd1,1'b1,7'h05,8'h00,8'h00,1'b1,4'd5},  // R5 read denied
    {2'd2,1'b1,7'h05,8'h11,8'h00,1'b1,4'd5},  // R5 write denied
    {2'd1,1'b0,7'h05,8'h00,8'hAA,1'b0,4'd9},  // R9 no change
    {2'd1,1'b1,7'h78,8'h00,8'h4E,1'b0,4'd8},  // R8 read ok
    {2'd2,1'b1,7'h78,8'hFF,8'h00,1'b1,4'd8},  // R8 denied
    {2'd1,1'b1,7'h78,8'h00,8'h4E,1'b0,4'd9},  // R9 no change
    {2'd2,1'b1,7'h7C,8'h5A,8'h00,1'b0,4'd8},  // R8 exempt 0x7C
    {2'd1,1'b1,7'h7C,8'h00,8'h5A,1'b0,4'd8},  // R8
    {2'd2,1'b0,7'h44,8'h12,8'h00,1'b0,4'd11}, // R11
    {2'd1,1'b1,7'h44,8'h00,8'h12,1'b0,4'd11}, // R11
    {2'd2,1'b0,7'h40,8'h10,8'h00,1'b0,4'd10}, // R10 bank 16
    {2'd1,1'b0,7'h05,8'h00,8'h00,1'b0,4'd10}, // R10 reads zero
    {2'd2,1'b0,7'h05,8'h99,8'h00,1'b0,4'd10}, // R10 write dropped
    {2'd2,1'b0,7'h40,8'h00,8'h00,1'b0,4'd10}, // R10 back to bank 0
    {2'd1,1'b0,7'h05,8'h00,8'hAA,1'b0,4'd10}, // R10 store untouched
    {2'd1,1'b0,7'h7E,8'h00,8'h69,1'b0,4'd1},  // R1
    {2'd1,1'b0,7'h7F,8'h00,8'h43,1'b0,4'd1},  // R1
    {2'd1,1'b0,7'h79,8'h00,8'h51,1'b0,4'd1},  // R1
    {2'd1,1'b0,7'h7A,8'h00,8'h43,1'b0,4'd1},  // R1
    {2'd1,1'b0,7'h7B,8'h00,8'h31,1'b0,4'd1},  // R1
    {2'd1,1'b0,7'h7D,8'h00,8'h00,1'b0,4'd1}   // R1
  };

  task automatic access(logic rd, logic wr, logic prot, logic [6:0] a, logic [7:0] d);
    rd_en = rd; wr_en = wr; cfg_prot = prot; addr = a; wdata = d;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #3_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int b = 0; b < 16; b++)
      for (int o = 0; o < 64; o++) mem[b][o] = 8'h00;
    repeat (2) @(negedge clk);
    check("R1 rdata", rdata, 8'h00);
    check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
    check("R1 access_error", {7'd0, access_error}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b1, 1'b0, 1'b0, 7'h40, 8'h00);
    check("R1 bank select", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      access(v[30:29] == 2'd1, v[30:29] == 2'd2, v[28], v[27:21], v[20:13]);
      if (v[30:29] == 2'd1) begin
        compared++;
        if (rdata !== v[12:5] || rd_valid !== 1'b1) begin
          mismatched++;
          $display("FAIL R%0d vec %0d rdata=%h valid=%b expected=%h valid=1",
                   v[3:0], i, rdata, rd_valid, v[12:5]);
        end
      end
      compared++;
      if (access_error !== v[4]) begin
        mismatched++;
        $display("FAIL R%0d vec %0d access_error=%b expected=%b",
                 v[3:0], i, access_error, v[4]);
      end
    end

    check("R10 R9 store write count", 8'(store_writes), 8'd4);

    // R3: valid lasts one cycle, data held
    access(1'b1, 1'b0, 1'b0, 7'h7E, 8'h00);
    check("R3 valid", {7'd0, rd_valid}, 8'h01);
    @(negedge clk);
    check("R3 valid drops", {7'd0, rd_valid}, 8'h00);
    check("R3 data held", rdata, 8'h69);
    // R3: both strobes, write wins
    access(1'b1, 1'b1, 1'b0, 7'h45, 8'h3D);
    check("R3 no valid on dual strobe", {7'd0, rd_valid}, 8'h00);
    access(1'b1, 1'b0, 1'b0, 7'h45, 8'h00);
    check("R3 dual strobe wrote", rdata, 8'h3D);

    // R2: combinational window outputs
    rd_en = 1'b0; wr_en = 1'b1; cfg_prot = 1'b0; addr = 7'h2A; wdata = 8'hC4;
    #1;
    check("R2 win_we", {7'd0, win_we}, 8'h01);
    check("R2 win_bank", {4'd0, win_bank}, 8'h00);
    check("R2 win_offset", {2'd0, win_offset}, 8'h2A);
    @(negedge clk);
    wr_en = 1'b0;
    access(1'b0, 1'b1, 1'b0, 7'h40, 8'h0C);
    rd_en = 1'b1; addr = 7'h3F;
    #1;
    check("R2 win_bank 12", {4'd0, win_bank}, 8'h0C);
    check("R2 win_offset 3F", {2'd0, win_offset}, 8'h3F);
    check("R2 no we on read", {7'd0, win_we}, 8'h00);
    @(negedge clk);
    rd_en = 1'b0;

    // R1: reset restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b1, 1'b0, 1'b0, 7'h7C, 8'h00);
    check("R1 0x7C after reset", rdata, 8'h00);
    access(1'b1, 1'b0, 1'b0, 7'h40, 8'h00);
    check("R1 0x40 after reset", rdata, 8'h00);
    access(1'b1, 1'b0, 1'b0, 7'h78, 8'h00);
    check("R1 0x78 after reset", rdata, 8'h4E);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule